// File: doc/BRIEF.md
# Shared Message-Interrupt Capture Bank

This block collects message-signaled interrupts into a small bank of shared 32-bit capture registers. An agent rings the doorbell with one write. The written word names a capture register in its top bits and a bit position inside that register in the next field down. The block ORs that bit into the register and, one cycle later, pulses the request line for that register toward the downstream interrupt controller. The controller treats each line as an edge-sensitive source.

The service routine reads a capture register to learn which messages arrived. The read returns the collected bits and empties the register in the same access. A summary word carries one bit per capture register and shows which registers still hold bits, so the routine can skip the empty ones. The bus has separate read and write channels, so a doorbell and a clearing read can land on the same register in the same cycle. In that case the new message is kept.

Top module: `msi_capture_bank`

## Requirements
- R1: After synchronous reset, every capture register reads as zero, the summary reads zero, no request line is high and `rd_valid` is low.
- R2: An aligned write to offset 0x140 is a doorbell. Data bits 31:29 give the register index and bits 28:24 give the bit position. The doorbell ORs that bit into that register.
- R3: A doorbell drives `irq_pulse[index]` high for exactly the cycle after the write. At most one request line is high in any cycle.
- R4: A read at offset 0x10*i, for i from 0 to 7, returns capture register i and clears it to zero.
- R5: A read at offset 0x120 returns a word in which bit i is 1 exactly when capture register i is non-zero. Bits 31:8 are zero.
- R6: An access whose address has any of bits 3:0 set has no effect. A read of this kind returns 0xFFFFFFFF and clears nothing. A write of this kind sets no bit and pulses no line.
- R7: A write to any aligned offset other than 0x140 changes no register and pulses no line.
- R8: When a doorbell and a clearing read hit the same register in the same cycle, the read returns the old contents and the register then holds only the newly set bit.
- R9: An aligned read of an offset that maps to nothing returns zero and has no side effect.
- R10: `rd_valid` is high in exactly the cycle after each cycle in which `rd_en` is high. `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | 9 | Byte offset of the read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 9 | Byte offset of the write |
| wr_data | input | 32 | Write data; doorbell fields in bits 31:24 |
| irq_pulse | output | 8 | One-cycle request per capture register |

## Verification
Some properties are checked on every cycle. A doorbell bit must land in its register. A clearing read must leave its register empty unless a doorbell also hits it. A collision must leave exactly the new bit. A register with no set and no clear must hold its value. Request lines must be at most one-hot and must appear only after a doorbell. Read-valid timing, the all-ones misaligned response, the zero unmapped response and the zero upper summary bits are checked on every read.

Other behaviour only the bench scenarios can show. These are the full contents returned across several doorbells, a misaligned write that leaves every register unchanged, the summary tracking registers as they fill and drain, and a collision seen end to end through the next read. All of these are compared against a bench model.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

  // Log2 of the spacing between register slots in the region.
  localparam int unsigned SLOT_SHIFT = 4;

  // What an incoming read resolves to.
  typedef enum logic [1:0] {
    RK_UNMAPPED   = 2'd0,
    RK_CAPTURE    = 2'd1,
    RK_SUMMARY    = 2'd2,
    RK_MISALIGNED = 2'd3
  } rd_kind_e;

endpackage

// File: rtl/msi_bus_decode.sv
module msi_bus_decode #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned REG_W       = 32,
  parameter int unsigned DOORBELL_OFS = 'h140,
  parameter int unsigned SUMMARY_OFS = 'h120,
  localparam int unsigned SEL_W      = $clog2(NUM_REGS),
  localparam int unsigned BIT_W      = $clog2(REG_W)
) (
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [SEL_W-1:0]          db_sel,
  input  logic [BIT_W-1:0]          db_bit,
  output msi_bank_pkg::rd_kind_e    rd_kind,
  output logic [SEL_W-1:0]          rd_idx,
  output logic [NUM_REGS-1:0]       clr_vec,
  output logic [NUM_REGS-1:0]       set_vec,
  output logic [BIT_W-1:0]          set_bit
);
  import msi_bank_pkg::*;

  localparam logic [ADDR_W-1:0] CAPTURE_END = ADDR_W'(NUM_REGS << SLOT_SHIFT);
  localparam logic [ADDR_W-1:0] SUMMARY_A   = ADDR_W'(SUMMARY_OFS);
  localparam logic [ADDR_W-1:0] DOORBELL_A  = ADDR_W'(DOORBELL_OFS);

  logic rd_misaligned;
  logic wr_aligned;
  logic db_hit;

  assign rd_misaligned = |rd_addr[SLOT_SHIFT-1:0];
  assign wr_aligned    = ~|wr_addr[SLOT_SHIFT-1:0];
  assign rd_idx        = rd_addr[SLOT_SHIFT +: SEL_W];
  assign db_hit        = wr_en && wr_aligned && (wr_addr == DOORBELL_A);
  assign set_bit       = db_bit;

  always_comb begin
    if (rd_misaligned)               rd_kind = RK_MISALIGNED;
    else if (rd_addr < CAPTURE_END)  rd_kind = RK_CAPTURE;
    else if (rd_addr == SUMMARY_A)   rd_kind = RK_SUMMARY;
    else                             rd_kind = RK_UNMAPPED;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
    assign clr_vec[g] = rd_en && (rd_kind == RK_CAPTURE) && (rd_idx == SEL_W'(g));
    assign set_vec[g] = db_hit && (db_sel == SEL_W'(g));
  end

endmodule

// File: rtl/msi_capture_reg.sv
module msi_capture_reg #(
  parameter int unsigned REG_W = 32,
  localparam int unsigned BIT_W = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic             set_en,
  input  logic [BIT_W-1:0] set_bit,
  output logic [REG_W-1:0] value_o,
  output logic             nonzero_o
);

  logic [REG_W-1:0] value_q;
  logic [REG_W-1:0] set_mask;
  logic [REG_W-1:0] kept;

  assign set_mask = set_en ? (REG_W'(1) << set_bit) : '0;
  assign kept     = clr_en ? '0 : value_q;

  always_ff @(posedge clk) begin
    if (rst) value_q <= '0;
    else     value_q <= kept | set_mask;
  end

  assign value_o   = value_q;
  assign nonzero_o = |value_q;

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((value_q & (REG_W'(1) << $past(set_bit))) != '0));

  assert_read_empties_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> (value_q == '0));

  assert_collision_new_only_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_en && set_en) |=> (value_q == (REG_W'(1) << $past(set_bit))));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && !set_en) |=> $stable(value_q));

endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 32,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_en,
  input  msi_bank_pkg::rd_kind_e          rd_kind,
  input  logic [SEL_W-1:0]                rd_idx,
  input  logic [NUM_REGS-1:0][REG_W-1:0]  values,
  input  logic [NUM_REGS-1:0]             summary,
  output logic                            rd_valid_o,
  output logic [DATA_W-1:0]               rd_data_o
);
  import msi_bank_pkg::*;

  logic [DATA_W-1:0] word;

  always_comb begin
    unique case (rd_kind)
      RK_CAPTURE:    word = DATA_W'(values[rd_idx]);
      RK_SUMMARY:    word = DATA_W'(summary);
      RK_MISALIGNED: word = '1;
      default:       word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en;
      if (rd_en) rd_data_o <= word;
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid_o);

  assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid_o);

  assert_misaligned_ones_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_kind == RK_MISALIGNED) |=> (rd_data_o == '1));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_kind == RK_UNMAPPED) |=> (rd_data_o == '0));

  assert_summary_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_kind == RK_SUMMARY) |=> ((rd_data_o >> NUM_REGS) == '0));

endmodule

// File: rtl/msi_capture_bank.sv
module msi_capture_bank #(
  parameter int unsigned ADDR_W       = 9,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned NUM_REGS     = 8,
  parameter int unsigned REG_W        = 32,
  parameter int unsigned DOORBELL_OFS = 'h140,
  parameter int unsigned SUMMARY_OFS  = 'h120
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_REGS-1:0] irq_pulse
);
  import msi_bank_pkg::*;

  localparam int unsigned SEL_W  = $clog2(NUM_REGS);
  localparam int unsigned BIT_W  = $clog2(REG_W);
  localparam int unsigned SEL_LO = DATA_W - SEL_W;
  localparam int unsigned BIT_LO = SEL_LO - BIT_W;
  localparam logic [ADDR_W-1:0] DOORBELL_A = ADDR_W'(DOORBELL_OFS);

  rd_kind_e                      rd_kind;
  logic [SEL_W-1:0]              rd_idx;
  logic [NUM_REGS-1:0]           clr_vec;
  logic [NUM_REGS-1:0]           set_vec;
  logic [BIT_W-1:0]              set_bit;
  logic [NUM_REGS-1:0][REG_W-1:0] reg_values;
  logic [NUM_REGS-1:0]           summary;
  logic                          unused_wdata_low;

  assign unused_wdata_low = ^wr_data[BIT_LO-1:0];

  msi_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .REG_W(REG_W),
    .DOORBELL_OFS(DOORBELL_OFS), .SUMMARY_OFS(SUMMARY_OFS)
  ) decode_i (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .db_sel  (wr_data[SEL_LO +: SEL_W]),
    .db_bit  (wr_data[BIT_LO +: BIT_W]),
    .rd_kind (rd_kind),
    .rd_idx  (rd_idx),
    .clr_vec (clr_vec),
    .set_vec (set_vec),
    .set_bit (set_bit)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    msi_capture_reg #(.REG_W(REG_W)) cap_i (
      .clk       (clk),
      .rst       (rst),
      .clr_en    (clr_vec[g]),
      .set_en    (set_vec[g]),
      .set_bit   (set_bit),
      .value_o   (reg_values[g]),
      .nonzero_o (summary[g])
    );
  end

  msi_read_mux #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .REG_W(REG_W)
  ) rmux_i (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_kind    (rd_kind),
    .rd_idx     (rd_idx),
    .values     (reg_values),
    .summary    (summary),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_pulse <= '0;
    else     irq_pulse <= set_vec;
  end

  assert_irq_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_pulse));

  assert_irq_needs_doorbell_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == DOORBELL_A) |=> (irq_pulse == '0));

endmodule

// File: tb/msi_capture_bank_tb.sv
`timescale 1ns/1ps
module msi_capture_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        rd_en;
  logic [8:0]  rd_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  irq_pulse;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  logic [31:0] model [8];

  always #5 clk = ~clk;

  msi_capture_bank dut_i (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_pulse(irq_pulse)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] summary_of();
    logic [31:0] s = '0;
    for (int i = 0; i < 8; i++) s[i] = (model[i] != 0);
    return s;
  endfunction

  function automatic logic [31:0] expect_read(input logic [8:0] a);
    if (a[3:0] != 4'h0)        return 32'hFFFF_FFFF;
    else if (a < 9'h080)       return model[a[6:4]];
    else if (a == 9'h120)      return summary_of();
    else                       return 32'h0;
  endfunction

  function automatic logic [31:0] door(input int r, input int b);
    return (32'(r) << 29) | (32'(b) << 24);
  endfunction

  // One bus cycle: drive at negedge, update model, check at next negedge.
  task automatic op(input bit re, input logic [8:0] ra,
                    input bit we, input logic [8:0] wa, input logic [31:0] wd,
                    input string tag);
    logic [31:0] exp_rd;
    logic [7:0]  exp_irq;
    rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
    exp_rd  = expect_read(ra);
    exp_irq = '0;
    if (re && ra[3:0] == 4'h0 && ra < 9'h080) model[ra[6:4]] = '0;
    if (we && wa == 9'h140) begin
      model[wd[31:29]] = model[wd[31:29]] | (32'h1 << wd[28:24]);
      exp_irq = 8'h1 << wd[31:29];
    end
    @(posedge clk);
    @(negedge clk);
    check(rd_valid == re, {tag, " R10 valid"}, 32'(rd_valid), 32'(re));
    if (re) check(rd_data == exp_rd, {tag, " data"}, rd_data, exp_rd);
    check(irq_pulse == exp_irq, {tag, " R3 irq"}, 32'(irq_pulse), 32'(exp_irq));
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  function automatic logic [8:0] pick_addr();
    int k = $urandom_range(0, 5);
    case (k)
      0, 1: return 9'($urandom_range(0, 7) << 4);
      2:    return 9'h120;
      3:    return 9'h140;
      4:    return 9'($urandom_range(0, 511) | 1);
      default: return 9'($urandom_range(0, 31) << 4);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) model[i] = '0;
    rst = 1'b1; rd_en = 0; wr_en = 0; rd_addr = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check(rd_valid == 1'b0, "R1 reset valid", 32'(rd_valid), 0);
    check(irq_pulse == 8'h0, "R1 reset irq", 32'(irq_pulse), 0);
    op(1, 9'h120, 0, 0, 0, "R1 summary after reset");
    op(1, 9'h030, 0, 0, 0, "R1 reg after reset");

    op(0, 0, 1, 9'h140, door(3, 7), "R2 doorbell r3 b7");
    op(1, 9'h120, 0, 0, 0, "R5 summary one reg");
    op(1, 9'h034, 0, 0, 0, "R6 misaligned read");
    op(0, 0, 1, 9'h144, door(1, 0), "R6 misaligned write");
    op(0, 0, 1, 9'h030, 32'hFFFF_FFFF, "R7 write to capture slot");
    op(0, 0, 1, 9'h120, 32'hFFFF_FFFF, "R7 write to summary");
    op(1, 9'h010, 0, 0, 0, "R6 R7 reg1 untouched");
    op(1, 9'h030, 0, 0, 0, "R4 read collects");
    op(1, 9'h030, 0, 0, 0, "R4 read cleared");
    op(1, 9'h100, 0, 0, 0, "R9 unmapped");
    op(1, 9'h140, 0, 0, 0, "R9 doorbell not readable");

    op(0, 0, 1, 9'h140, door(5, 2), "R2 doorbell r5 b2");
    op(1, 9'h050, 1, 9'h140, door(5, 9), "R8 collision");
    op(1, 9'h050, 0, 0, 0, "R8 new bit kept");
    op(0, 0, 1, 9'h140, door(7, 31), "R2 top bit");
    op(0, 0, 1, 9'h140, door(0, 0), "R3 back to back");
    op(1, 9'h120, 0, 0, 0, "R5 summary two regs");
    op(1, 9'h070, 0, 0, 0, "R4 reg7");
    op(1, 9'h000, 0, 0, 0, "R4 reg0");
    op(1, 9'h120, 0, 0, 0, "R5 summary empty");

    for (int n = 0; n < 3000; n++) begin
      bit re = 1'($urandom_range(0, 1));
      bit we = 1'($urandom_range(0, 1));
      logic [8:0] ra = pick_addr();
      logic [8:0] wa = pick_addr();
      op(re, ra, we, wa, $urandom(), "R2 R4 R5 R6 R7 R8 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule